// File: doc/BRIEF.md
# Register-Based Page Table Translator

This block turns a 16-bit virtual address into a 15-bit physical address using 4 KB pages. The whole page table sits in sixteen on-chip registers, one per virtual page. Each register holds a 3-bit frame number and a present flag. Because the top four address bits index a register directly, no memory access is needed during translation.

A host write port loads entries one at a time, for example when a new process is switched in. A lookup port accepts one virtual address per cycle. One cycle later it returns the physical address together with a valid flag and a page-fault flag. If a lookup hits a page whose entry is marked absent, the block raises a fault instead of producing an address.

Top module: `page_xlate`

## Requirements
- R1: On a successful lookup, bits [11:0] of `pa` equal bits [11:0] of the requested `va`.
- R2: On a successful lookup, bits [14:12] of `pa` hold the frame number stored in entry `va[15:12]`.
- R3: A lookup of an entry whose present bit is 0 gives `rsp_fault`=1, `rsp_valid`=0 and `pa`=0.
- R4: The results of a request asserted in cycle N appear in cycle N+1. In a cycle that follows one with `req`=0, `rsp_valid` and `rsp_fault` are 0 and `pa` is 0.
- R5: A write (`wr_en`=1) updates entry `wr_idx` at the next rising edge. A lookup of that entry in the same cycle returns the entry's old contents.
- R6: While `rst` is high at a rising edge, every present bit is cleared and all outputs go to 0. After reset, every page faults until it is written.
- R7: A write changes only the entry selected by `wr_idx`. Every other entry keeps its frame number and present bit.
- R8: `rsp_valid` and `rsp_fault` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for one table entry |
| wr_idx | input | 4 | Entry (virtual page) to write |
| wr_frame | input | 3 | Frame number to store |
| wr_present | input | 1 | Present bit to store |
| req | input | 1 | Lookup request |
| va | input | 16 | Virtual address to translate |
| rsp_valid | output | 1 | Registered: translation succeeded |
| rsp_fault | output | 1 | Registered: page was absent |
| pa | output | 15 | Registered physical address, 0 unless valid |

## Verification
Every lookup result, whether `rsp_valid`, `rsp_fault` or `pa`, is due exactly one rising edge after the request. A table write becomes visible to lookups issued after that same edge. The bench drives each request on a falling edge and samples the outputs on the next falling edge, so exactly one rising edge has passed. For the same-cycle write-and-lookup case, the bench issues the request and the write together. It checks that the old entry comes back, and then that the new entry is returned on the following request.

// File: rtl/page_xlate.sv
module page_xlate #(
  parameter int VA_W  = 16,
  parameter int PA_W  = 15,
  parameter int OFF_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [VA_W-OFF_W-1:0] wr_idx,
  input  logic [PA_W-OFF_W-1:0] wr_frame,
  input  logic              wr_present,
  input  logic              req,
  input  logic [VA_W-1:0]   va,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [PA_W-1:0]   pa
);
  localparam int VPN_W   = VA_W - OFF_W;
  localparam int PFN_W   = PA_W - OFF_W;
  localparam int ENTRIES = 1 << VPN_W;

  logic [PFN_W-1:0] frame_q [ENTRIES];
  logic [ENTRIES-1:0] present_q;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        present_q[i] <= 1'b0;
        frame_q[i]   <= '0;
      end else if (wr_en && wr_idx == VPN_W'(i)) begin
        present_q[i] <= wr_present;
        frame_q[i]   <= wr_frame;
      end
    end
  end

  wire [VPN_W-1:0] vpn = va[VA_W-1:OFF_W];
  wire             hit = present_q[vpn];

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      pa        <= '0;
    end else begin
      rsp_valid <= req && hit;
      rsp_fault <= req && !hit;
      pa        <= (req && hit) ? {frame_q[vpn], va[OFF_W-1:0]} : '0;
    end
  end

  // R8
  excl_flags_chk: assert property (@(posedge clk) disable iff (rst)
    !(rsp_valid && rsp_fault));

  // R3
  fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (pa == '0 && !rsp_valid));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!req && !rst) |=> (!rsp_valid && !rsp_fault && pa == '0));

  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (req && !rst) |=> (!rsp_valid || pa[OFF_W-1:0] == $past(va[OFF_W-1:0])));

  // R6
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!rsp_valid && !rsp_fault && pa == '0));
endmodule

// File: tb/page_xlate_tb.sv
module page_xlate_tb;
  logic clk = 0, rst = 1;
  logic wr_en = 0, wr_present = 0, req = 0;
  logic [3:0] wr_idx = 0;
  logic [2:0] wr_frame = 0;
  logic [15:0] va = 0;
  logic rsp_valid, rsp_fault;
  logic [14:0] pa;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  page_xlate u_dut (.clk, .rst, .wr_en, .wr_idx, .wr_frame, .wr_present,
                    .req, .va, .rsp_valid, .rsp_fault, .pa);

  // pages 0..5, 9, 11 present
  localparam logic [15:0] PRES = 16'h0A3F;
  localparam logic [2:0] FRM [16] = '{3'd2, 3'd1, 3'd6, 3'd0, 3'd4, 3'd3, 3'd0, 3'd0,
                                      3'd0, 3'd5, 3'd0, 3'd7, 3'd0, 3'd0, 3'd0, 3'd0};
  // {va, valid, fault, pa}
  localparam logic [32:0] VEC [10] = '{
    {16'h3441, 1'b1, 1'b0, 15'h0441},
    {16'h0440, 1'b1, 1'b0, 15'h2440},
    {16'hB443, 1'b1, 1'b0, 15'h7443},
    {16'h344C, 1'b1, 1'b0, 15'h044C},
    {16'h2004, 1'b1, 1'b0, 15'h6004},
    {16'h9FFF, 1'b1, 1'b0, 15'h5FFF},
    {16'h5123, 1'b1, 1'b0, 15'h3123},
    {16'h6ABC, 1'b0, 1'b1, 15'h0000},
    {16'hF000, 1'b0, 1'b1, 15'h0000},
    {16'hAFFF, 1'b0, 1'b1, 15'h0000}};

  task automatic expect3(string tag, logic v, logic f, logic [14:0] p);
    checks++;
    if (rsp_valid !== v || rsp_fault !== f || pa !== p) begin
      fails++;
      $display("FAIL %s: got valid=%b fault=%b pa=%h, expected valid=%b fault=%b pa=%h",
               tag, rsp_valid, rsp_fault, pa, v, f, p);
    end
  endtask

  task automatic wr(int idx, int frm, bit pr);
    @(negedge clk);
    wr_en = 1; wr_idx = 4'(idx); wr_frame = 3'(frm); wr_present = pr;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look(logic [15:0] a);
    @(negedge clk);
    req = 1; va = a;
    @(negedge clk);
    req = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R6: reset state and all pages absent
    expect3("R6 reset outputs", 0, 0, 0);
    look(16'h0123);
    expect3("R6 absent after reset", 0, 1, 0);

    for (int i = 0; i < 16; i++) wr(i, FRM[i], PRES[i]);

    // R1 R2 R3: vector table
    foreach (VEC[k]) begin
      look(VEC[k][32:17]);
      expect3("R1/R2/R3 vector", VEC[k][16], VEC[k][15], VEC[k][14:0]);
    end

    // R4: idle cycle quiet
    @(negedge clk);
    expect3("R4 idle after request", 0, 0, 0);

    // R4: back-to-back requests, one cycle each
    @(negedge clk); req = 1; va = 16'h1777;
    @(negedge clk); va = 16'h8000;
    expect3("R4 first of pair", 1, 0, 15'h1777);
    @(negedge clk); req = 0;
    expect3("R4 second of pair", 0, 1, 0);

    // R5: same-cycle write and lookup sees old entry
    @(negedge clk);
    wr_en = 1; wr_idx = 4'd3; wr_frame = 3'd5; wr_present = 1;
    req = 1; va = 16'h3010;
    @(negedge clk);
    wr_en = 0; req = 0;
    expect3("R5 old entry same cycle", 1, 0, 15'h0010);
    look(16'h3010);
    expect3("R5 new entry next cycle", 1, 0, 15'h5010);

    // R7: neighbours untouched
    look(16'h4ABC);
    expect3("R7 page 4 unchanged", 1, 0, 15'h4ABC);
    look(16'h2004);
    expect3("R7 page 2 unchanged", 1, 0, 15'h6004);

    // R3: clearing present bit makes page fault
    wr(9, 5, 0);
    look(16'h9FFF);
    expect3("R3 cleared page faults", 0, 1, 0);
    // R2: absent page made present
    wr(15, 7, 1);
    look(16'hF00F);
    expect3("R2 new page 15", 1, 0, 15'h700F);

    // R6: mid-run reset clears table
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    expect3("R6 outputs after reset", 0, 0, 0);
    look(16'h0440);
    expect3("R6 page 0 absent after reset", 0, 1, 0);

    // R8: covered by every check above (valid and fault never both 1)
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule